// File: doc/BRIEF.md
# Receive Character Store with Deferred Status

This block sits between a serial deserialiser and a register interface. It keeps each received character with its error flags and hands them out in arrival order. A single mode input sets the store's size. In character mode it holds exactly one entry, like a holding register. In queue mode it holds `DEPTH` entries. Each entry carries the received byte and four status flags: framing error, parity error, break, and a marker showing that characters were lost just before this one.

Software reads a character through a data-read strobe. The data word presents the oldest entry, and the strobe removes it. A separate four-bit status word is not updated as characters arrive. It takes the framing, parity and break flags of a character only when that character is read out. Its loss bit is different: it rises at once when an arriving character finds the store full. An error-clear strobe zeroes the status word. If the store holds entries when the mode input changes, they are discarded.

Top module: `rx_holding_store`

## Requirements
- R1: After reset, `rx_empty` is 1, `rx_full` is 0, and `status_word` and `data_word` are all zeros.
- R2: `data_word` shows the oldest stored entry, or zero when the store is empty. The entry layout is: byte in bits DATA_W-1:0, framing error at bit DATA_W, parity error at DATA_W+1, break at DATA_W+2, and the loss marker at DATA_W+3.
- R3: With `fifo_en` low, the store holds one entry. `rx_full` is 1 exactly when that entry is occupied.
- R4: With `fifo_en` high, the store holds `DEPTH` entries (16 by default) and returns them in arrival order. `rx_full` is 1 when all of them are occupied. `rx_empty` and `rx_full` are never 1 together.
- R5: A character that arrives while the store is full, in a cycle with no data read, is discarded. The stored entries are kept, and `status_word[3]` is 1 from the next cycle on.
- R6: The first character stored after such a loss carries the loss marker set to 1. Characters stored later carry 0.
- R7: A data read on a non-empty store removes the oldest entry and loads its framing, parity and break flags into `status_word[2:0]`. A data read on an empty store changes nothing.
- R8: `status_word` keeps its value while characters are stored, until the next data read, clear or loss. A status read before the data read therefore returns the previous character's flags.
- R9: `clr_err` zeroes all four status bits. It overrides a data read in the same cycle. A loss in the same cycle still leaves bit 3 at 1.
- R10: When the store is full, a data read and an arrival in the same cycle both take effect, and no loss is recorded.
- R11: A change of `fifo_en` empties the store at the next clock edge. No data read or arrival takes effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode (DEPTH entries), 0 selects single-entry mode |
| rx_valid | input | 1 | Strobe: one received character is present |
| rx_byte | input | DATA_W | Received byte |
| rx_frm | input | 1 | Framing error flag for the received character |
| rx_par | input | 1 | Parity error flag for the received character |
| rx_brk | input | 1 | Break flag for the received character |
| rd_data | input | 1 | Data-read strobe; removes the oldest entry |
| clr_err | input | 1 | Error-clear strobe |
| data_word | output | DATA_W+4 | Oldest entry: flags above the byte |
| status_word | output | 4 | Latched status: loss, break, parity, framing (bit 3 to bit 0) |
| rx_empty | output | 1 | Store holds no entry |
| rx_full | output | 1 | Store is at its current capacity |

## Verification
The checker's properties assume three things about the inputs. The mode input changes only between clock edges. The strobes are single-cycle pulses sampled at the rising edge. An arrival, a read and a clear may coincide in any combination. The properties that involve reads or losses exclude the cycle in which a mode change flushes the store, since in that cycle those strobes have no effect. The stimulus follows these rules. It drives every input just after a falling edge and changes `fifo_en` only with the other strobes idle. The deliberate coincidences (a full store with read plus arrival, and a clear together with a loss) are then compared cycle by cycle against a reference queue.

// File: rtl/rx_store_pkg.sv
package rx_store_pkg;
   // Number of per-character status flags carried alongside the byte.
   localparam int STAT_W = 4;

   // Status bit positions, lowest first.
   localparam int ST_FRM = 0;
   localparam int ST_PAR = 1;
   localparam int ST_BRK = 2;
   localparam int ST_OVR = 3;

   typedef struct packed {
      logic ovr;
      logic brk;
      logic par;
      logic frm;
   } rx_flags_t;
endpackage

// File: rtl/rx_entry_fifo.sv
module rx_entry_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             cap_one,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full,
   output logic             accepted,
   output logic             dropped,
   output logic             popped
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CAP_MAX = CW'(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PW-1:0]    wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CW-1:0]    count_q;
   logic [CW-1:0]    cap;

   assign cap   = cap_one ? CW'(1) : CAP_MAX;
   assign empty = (count_q == '0);
   assign full  = (count_q == cap);

   assign popped   = pop_req && !empty && !flush;
   assign accepted = push_req && !flush && (!full || popped);
   assign dropped  = push_req && !flush && full && !popped;

   // Pointer advance: free wrap for power-of-two depths, explicit otherwise.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_free
         assign wr_nxt = wr_ptr_q + PW'(1);
         assign rd_nxt = rd_ptr_q + PW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + PW'(1);
         assign rd_nxt = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (accepted) mem_q[wr_ptr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else if (flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (accepted) wr_ptr_q <= wr_nxt;
         if (popped)   rd_ptr_q <= rd_nxt;
         case ({accepted, popped})
            2'b10:   count_q <= count_q + CW'(1);
            2'b01:   count_q <= count_q - CW'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   assign rdata = empty ? '0 : mem_q[rd_ptr_q];
endmodule

// File: rtl/rx_status_reg.sv
module rx_status_reg
   import rx_store_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       load,
   input  rx_flags_t  load_flags,
   input  logic       ovr_set,
   output rx_flags_t  status
);
   rx_flags_t stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         // Character flags: clear beats a read-time load.
         if (clr) begin
            stat_q.frm <= 1'b0;
            stat_q.par <= 1'b0;
            stat_q.brk <= 1'b0;
         end else if (load) begin
            stat_q.frm <= load_flags.frm;
            stat_q.par <= load_flags.par;
            stat_q.brk <= load_flags.brk;
         end
         // Loss flag: an event in the same cycle beats the clear.
         if (ovr_set)  stat_q.ovr <= 1'b1;
         else if (clr) stat_q.ovr <= 1'b0;
      end
   end

   assign status = stat_q;
endmodule

// File: rtl/rx_holding_store.sv
module rx_holding_store
   import rx_store_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fifo_en,
   input  logic                     rx_valid,
   input  logic [DATA_W-1:0]        rx_byte,
   input  logic                     rx_frm,
   input  logic                     rx_par,
   input  logic                     rx_brk,
   input  logic                     rd_data,
   input  logic                     clr_err,
   output logic [DATA_W+STAT_W-1:0] data_word,
   output logic [STAT_W-1:0]        status_word,
   output logic                     rx_empty,
   output logic                     rx_full
);
   localparam int ENTRY_W = DATA_W + STAT_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_holding_store: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_holding_store: DATA_W must be positive");
      end
   endgenerate

   logic               mode_q;
   logic               flush;
   logic               lost_q;
   logic               accepted, dropped, popped;
   logic [ENTRY_W-1:0] wr_entry, head;
   rx_flags_t          in_flags, head_flags, stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= fifo_en;
   end
   assign flush = (fifo_en != mode_q);

   // Loss marker waiting for the next stored character.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lost_q <= 1'b0;
      else if (flush)    lost_q <= 1'b0;
      else if (dropped)  lost_q <= 1'b1;
      else if (accepted) lost_q <= 1'b0;
   end

   assign in_flags = '{ovr: lost_q, brk: rx_brk, par: rx_par, frm: rx_frm};
   assign wr_entry = {in_flags, rx_byte};

   rx_entry_fifo #(
      .DEPTH (DEPTH),
      .WIDTH (ENTRY_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .cap_one  (!fifo_en),
      .push_req (rx_valid),
      .pop_req  (rd_data),
      .wdata    (wr_entry),
      .rdata    (head),
      .empty    (rx_empty),
      .full     (rx_full),
      .accepted (accepted),
      .dropped  (dropped),
      .popped   (popped)
   );

   assign head_flags = rx_flags_t'(head[ENTRY_W-1:DATA_W]);

   rx_status_reg i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_err),
      .load       (popped),
      .load_flags (head_flags),
      .ovr_set    (dropped),
      .status     (stat)
   );

   assign data_word   = head;
   assign status_word = stat;
endmodule

// File: rtl/rx_holding_store_chk.sv
module rx_holding_store_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_en,
   input logic              rx_valid,
   input logic              rd_data,
   input logic              clr_err,
   input logic [DATA_W+3:0] data_word,
   input logic [3:0]        status_word,
   input logic              rx_empty,
   input logic              rx_full
);
   assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_empty && rx_full));

   assert_single_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && !$past(fifo_en)) |-> (rx_empty || rx_full));

   assert_loss_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full && !rd_data && (fifo_en == $past(fifo_en)))
      |=> status_word[3]);

   assert_read_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_empty && !clr_err && (fifo_en == $past(fifo_en)))
      |=> (status_word[2:0] == $past(data_word[DATA_W+2:DATA_W])));

   assert_status_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data && !clr_err && !(rx_valid && rx_full)) |=> $stable(status_word));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_err && !(rx_valid && rx_full && !rd_data)) |=> (status_word == 4'b0000));
endmodule

bind rx_holding_store rx_holding_store_chk #(.DATA_W(DATA_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_en     (fifo_en),
   .rx_valid    (rx_valid),
   .rd_data     (rd_data),
   .clr_err     (clr_err),
   .data_word   (data_word),
   .status_word (status_word),
   .rx_empty    (rx_empty),
   .rx_full     (rx_full)
);

// File: tb/test_rx_holding_store.sv
module test_rx_holding_store;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fifo_en = 1'b0;
   logic              rx_valid = 1'b0;
   logic [DATA_W-1:0] rx_byte = '0;
   logic              rx_frm = 1'b0, rx_par = 1'b0, rx_brk = 1'b0;
   logic              rd_data = 1'b0;
   logic              clr_err = 1'b0;
   logic [DATA_W+3:0] data_word;
   logic [3:0]        status_word;
   logic              rx_empty, rx_full;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // Reference model state
   logic [DATA_W+3:0] exp_q[$];
   int                cap = 1;
   logic              m_lost = 1'b0;
   logic [3:0]        m_stat = 4'b0000;

   always #10 clk = ~clk;

   rx_holding_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_holding_store (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_frm(rx_frm), .rx_par(rx_par), .rx_brk(rx_brk),
      .rd_data(rd_data), .clr_err(clr_err), .data_word(data_word),
      .status_word(status_word), .rx_empty(rx_empty), .rx_full(rx_full)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Compare every output against the reference model.
   task automatic check_all(input string req);
      logic [DATA_W+3:0] head;
      head = (exp_q.size() > 0) ? exp_q[0] : '0;
      chk(rx_empty == (exp_q.size() == 0), req, "rx_empty", 32'(rx_empty), 32'(exp_q.size() == 0));
      chk(rx_full == (exp_q.size() == cap), req, "rx_full", 32'(rx_full), 32'(exp_q.size() == cap));
      chk(status_word == m_stat, req, "status_word", 32'(status_word), 32'(m_stat));
      chk(data_word == head, req, "data_word (R2)", 32'(data_word), 32'(head));
   endtask

   // Driver: one cycle of stimulus, model updated, monitor compares.
   task automatic op(input bit v, input logic [DATA_W-1:0] b, input logic [2:0] brk_par_frm,
                     input bit rd, input bit clr, input string req);
      bit full_m, pop_m, ovf_m, push_m;
      logic [DATA_W+3:0] head;
      full_m = (exp_q.size() == cap);
      pop_m  = rd && (exp_q.size() > 0);
      ovf_m  = v && full_m && !pop_m;
      push_m = v && !ovf_m;
      @(negedge clk);
      rx_valid = v; rx_byte = b;
      {rx_brk, rx_par, rx_frm} = brk_par_frm;
      rd_data = rd; clr_err = clr;
      head = '0;
      if (pop_m) begin
         head = exp_q.pop_front();
         chk(data_word == head, "R2", "read word", 32'(data_word), 32'(head));
      end
      if (push_m) begin
         exp_q.push_back({m_lost, brk_par_frm, b});
         m_lost = 1'b0;
      end
      if (ovf_m) m_lost = 1'b1;
      if (clr)        m_stat[2:0] = 3'b000;
      else if (pop_m) m_stat[2:0] = head[DATA_W+2:DATA_W];
      if (ovf_m)      m_stat[3] = 1'b1;
      else if (clr)   m_stat[3] = 1'b0;
      @(negedge clk);
      rx_valid = 1'b0; rd_data = 1'b0; clr_err = 1'b0;
      check_all(req);
   endtask

   task automatic set_mode(input bit m, input string req);
      @(negedge clk);
      fifo_en = m;
      @(negedge clk);
      exp_q.delete();
      m_lost = 1'b0;
      cap = m ? DEPTH : 1;
      check_all(req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // Single-entry mode
      op(1, 8'h41, 3'b001, 0, 0, "R3");           // framing flagged
      op(1, 8'h42, 3'b000, 0, 0, "R5");           // dropped, loss visible
      op(0, 8'h00, 3'b000, 0, 0, "R8");           // status unchanged while idle
      op(0, 8'h00, 3'b000, 1, 0, "R7");           // read loads framing flag
      op(1, 8'h43, 3'b010, 0, 0, "R6");           // entry carries loss marker
      op(0, 8'h00, 3'b000, 0, 0, "R8");           // still previous char flags
      op(0, 8'h00, 3'b000, 1, 0, "R7");
      op(1, 8'h44, 3'b100, 0, 0, "R6");           // marker no longer set
      op(0, 8'h00, 3'b000, 1, 1, "R9");           // clear wins over load
      op(0, 8'h00, 3'b000, 1, 0, "R7");           // read on empty ignored

      // Queue mode
      set_mode(1, "R11");
      for (int i = 0; i < DEPTH; i++)
         op(1, 8'(8'h10 + i), 3'(i % 8), 0, 0, "R4");
      op(1, 8'hEE, 3'b111, 0, 0, "R5");           // loss when full
      op(0, 8'h00, 3'b000, 0, 1, "R9");
      op(1, 8'h55, 3'b011, 1, 0, "R10");          // read and arrival together
      op(1, 8'h66, 3'b000, 0, 1, "R9");           // loss with clear: bit 3 set
      op(0, 8'h00, 3'b000, 1, 0, "R7");
      op(1, 8'h67, 3'b101, 0, 0, "R6");
      for (int i = 0; i < DEPTH; i++)
         op(0, 8'h00, 3'b000, 1, 0, "R4");
      op(0, 8'h00, 3'b000, 1, 0, "R7");           // empty read ignored

      // Flush on mode change
      op(1, 8'hA1, 3'b001, 0, 0, "R4");
      op(1, 8'hA2, 3'b010, 0, 0, "R4");
      op(1, 8'hA3, 3'b100, 0, 0, "R4");
      set_mode(0, "R11");
      op(1, 8'hB0, 3'b000, 0, 0, "R3");
      op(0, 8'h00, 3'b000, 1, 0, "R7");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule